// File: doc/BRIEF.md
# Multi-Domain Power-On Reset Sequencer

This block sits between the board-level power-up reset and three reset domains: a control processor, a signal processor and a peripheral whose digital logic clears asynchronously. While the power-up reset input is low everything downstream is held in reset. When it rises, the block starts a half-rate clock to the control processor, holds that processor's reset for a fixed number of its own clock cycles and then releases it. Both processors reset synchronously, so each one gets a running clock while its reset is held.

The signal processor and the peripheral stay in reset after the control processor starts. The control processor releases them by writing a control word through a small write port. A later write can put them back into reset. The same control word gates a slow-clock domain, which stays silent until software enables it. The block also decides which way each shared bidirectional pin points. Until the processor on the far side has left reset, every shared pin on this side is turned to input, so the two sides never drive against each other. All clock outputs pass through glitch-free gates, and each reset output is released through a two-flop synchronizer in its own destination clock.

Top module: `rst_domain_seq`

## Requirements
- R1: While `pwrup_rst_n` is 0, `mcu_rst_n`, `dsp_rst_n` and `periph_rst_n` are 0, and both pad output-enable vectors are 0. Lowering `pwrup_rst_n` clears the control word, so after power returns the signal processor and the peripheral are in reset again.
- R2: `clk_slow_out` has no rising edge until bit 1 of the control word is 1. Once that bit is set, it follows `clk_slow`. Writing bit 1 back to 0 stops it again.
- R3: `clk_mcu` is quiet while `pwrup_rst_n` is 0. After the rise it toggles at half the `clk_main` rate, one rising edge every two `clk_main` periods, while `mcu_rst_n` is still 0.
- R4: Counting rising edges of `clk_mcu` from the rise of `pwrup_rst_n`, `mcu_rst_n` is 0 after each of edges 1 to MCU_HOLD_CYCLES+1 and 1 from edge MCU_HOLD_CYCLES+2 onward (130 with the default of 128).
- R5: `clk_dsp` follows `clk_main` from a few cycles after `pwrup_rst_n` rises, while `dsp_rst_n` is still 0. It is quiet while `pwrup_rst_n` is 0.
- R6: After the control processor leaves reset, `dsp_rst_n` and `periph_rst_n` stay 0 until a write sets bit 0 of the control word. Both are 1 within four `clk_main` cycles of the `clk_mcu` edge that captures that write.
- R7: A write that clears bit 0 drives `dsp_rst_n` and `periph_rst_n` back to 0 within four `clk_main` cycles.
- R8: The control word lives at address 0. A write takes effect only when `wr_en` is 1 at a rising edge of `clk_mcu`, `wr_addr` equals 0 and `mcu_rst_n` is already 1. Writes to any other address, and writes made while the control processor is in reset, change nothing.
- R9: `pad_oe_mcu` equals `core_oe_mcu` while `mcu_rst_n` is 1 and is 0 otherwise. `pad_oe_dsp` equals `core_oe_dsp` while `dsp_rst_n` is 1 and is 0 otherwise.
- R10: A fall of `pwrup_rst_n` drives `periph_rst_n`, `dsp_rst_n` and `mcu_rst_n` to 0 at once, without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Master clock |
| clk_slow | input | 1 | Free-running slow oscillator clock |
| pwrup_rst_n | input | 1 | Power-up reset, active low, asynchronous |
| wr_en | input | 1 | Control write strobe (clk_mcu domain) |
| wr_addr | input | AW | Control write address |
| wr_data | input | 2 | Control word: bit 0 releases the signal processor and peripheral, bit 1 enables the slow clock |
| core_oe_mcu | input | MCU_IO_W | Requested output enables for pins shared with the control processor |
| core_oe_dsp | input | DSP_IO_W | Requested output enables for pins shared with the signal processor |
| clk_mcu | output | 1 | Gated half-rate clock to the control processor |
| clk_dsp | output | 1 | Gated full-rate clock to the signal processor |
| clk_slow_out | output | 1 | Gated slow clock |
| mcu_rst_n | output | 1 | Control processor reset, active low |
| dsp_rst_n | output | 1 | Signal processor reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low, asserted asynchronously |
| pad_oe_mcu | output | MCU_IO_W | Effective output enables on control-processor shared pins |
| pad_oe_dsp | output | DSP_IO_W | Effective output enables on signal-processor shared pins |

## Verification
On every `clk_main` cycle the assertions check four things: shared pins never drive toward a processor that is in reset, neither the signal processor nor the peripheral is ever out of reset while the control processor is in it, the control processor is never released before its hold count completes, and every reset output is low whenever the power-up reset is low. Other behaviours can only be shown by the bench's scenarios. These are the exact edge on which the control processor is released, the half-rate period of its clock, the slow clock staying silent until it is enabled, the ignored writes (during reset and to a wrong address), the release and reassertion latency after a write, and the control word being lost across a power cycle.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;

    localparam int unsigned MCU_HOLD_DEF = 128;
    localparam int unsigned MCU_IO_W_DEF = 8;
    localparam int unsigned DSP_IO_W_DEF = 16;
    localparam int unsigned AW_DEF       = 4;

    // control word layout, decoded by the reset and gating logic
    localparam int unsigned CTL_DSP_BIT  = 0;
    localparam int unsigned CTL_SLOW_BIT = 1;
    localparam int unsigned CTL_W        = 2;

    // gated clock slots
    localparam int unsigned GATE_MAIN = 0;
    localparam int unsigned GATE_MCU  = 1;
    localparam int unsigned GATE_SLOW = 2;
    localparam int unsigned NUM_GATES = 3;

    typedef struct packed {
        logic slow_en;
        logic dsp_run;
    } ctl_t;

    function automatic ctl_t unpack_ctl(input logic [CTL_W-1:0] bits);
        ctl_t c;
        c.dsp_run = bits[CTL_DSP_BIT];
        c.slow_en = bits[CTL_SLOW_BIT];
        return c;
    endfunction

endpackage

// File: rtl/rsq_sync2.sv
`timescale 1ns/1ps
module rsq_sync2 (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);
    logic stage1;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            stage1 <= 1'b0;
            q      <= 1'b0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/rsq_clk_gate.sv
`timescale 1ns/1ps
module rsq_clk_gate (
    input  logic clk_src,
    input  logic en,
    output logic clk_out
);
    logic en_lat;

    // enable passes only while the source clock is low
    always_latch begin
        if (!clk_src) en_lat = en;
    end

    assign clk_out = clk_src & en_lat;
endmodule

// File: rtl/rsq_hold_cnt.sv
`timescale 1ns/1ps
module rsq_hold_cnt #(
    parameter int unsigned HOLD = rsq_pkg::MCU_HOLD_DEF
) (
    input  logic clk,
    input  logic clr_n,
    output logic done
);
    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)            cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIMIT);
endmodule

// File: rtl/rsq_ctl_reg.sv
`timescale 1ns/1ps
module rsq_ctl_reg
    import rsq_pkg::*;
#(
    parameter int unsigned AW       = AW_DEF,
    parameter int unsigned CTL_ADDR = 0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             wr_allow,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_t             ctl
);
    localparam logic [AW-1:0] HIT = AW'(CTL_ADDR);

    logic accept;
    assign accept = wr_en && wr_allow && (wr_addr == HIT);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      ctl <= '0;
        else if (accept) ctl <= unpack_ctl(wr_data);
    end
endmodule

// File: rtl/rst_domain_seq.sv
`timescale 1ns/1ps
module rst_domain_seq
    import rsq_pkg::*;
#(
    parameter int unsigned MCU_HOLD_CYCLES = MCU_HOLD_DEF,
    parameter int unsigned MCU_IO_W        = MCU_IO_W_DEF,
    parameter int unsigned DSP_IO_W        = DSP_IO_W_DEF,
    parameter int unsigned AW              = AW_DEF
) (
    input  logic                clk_main,
    input  logic                clk_slow,
    input  logic                pwrup_rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [CTL_W-1:0]    wr_data,
    input  logic [MCU_IO_W-1:0] core_oe_mcu,
    input  logic [DSP_IO_W-1:0] core_oe_dsp,
    output logic                clk_mcu,
    output logic                clk_dsp,
    output logic                clk_slow_out,
    output logic                mcu_rst_n,
    output logic                dsp_rst_n,
    output logic                periph_rst_n,
    output logic [MCU_IO_W-1:0] pad_oe_mcu,
    output logic [DSP_IO_W-1:0] pad_oe_dsp
);
    logic main_up;
    logic mcu_en_q;
    logic div_q;
    logic hold_done;
    logic slow_en_s;
    ctl_t ctl;

    logic [NUM_GATES-1:0] g_src;
    logic [NUM_GATES-1:0] g_en;
    logic [NUM_GATES-1:0] g_out;

    // power-up reset synchronized into the master domain
    rsq_sync2 u_up_sync (
        .clk(clk_main), .clr_n(pwrup_rst_n), .d(1'b1), .q(main_up)
    );

    // half-rate source: toggling starts one cycle after its gate enable is set
    always_ff @(posedge clk_main or negedge pwrup_rst_n) begin
        if (!pwrup_rst_n) begin
            mcu_en_q <= 1'b0;
            div_q    <= 1'b0;
        end else begin
            mcu_en_q <= main_up;
            if (mcu_en_q) div_q <= ~div_q;
        end
    end

    assign g_src[GATE_MAIN] = clk_main;
    assign g_src[GATE_MCU]  = div_q;
    assign g_src[GATE_SLOW] = clk_slow;
    assign g_en[GATE_MAIN]  = main_up;
    assign g_en[GATE_MCU]   = mcu_en_q;
    assign g_en[GATE_SLOW]  = slow_en_s;

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        rsq_clk_gate u_gate (
            .clk_src(g_src[g]), .en(g_en[g]), .clk_out(g_out[g])
        );
    end

    assign clk_dsp      = g_out[GATE_MAIN];
    assign clk_mcu      = g_out[GATE_MCU];
    assign clk_slow_out = g_out[GATE_SLOW];

    // control processor: fixed hold on its own clock, then synchronized release
    rsq_hold_cnt #(.HOLD(MCU_HOLD_CYCLES)) u_hold (
        .clk(clk_mcu), .clr_n(pwrup_rst_n), .done(hold_done)
    );

    rsq_sync2 u_mcu_rst (
        .clk(clk_mcu), .clr_n(pwrup_rst_n), .d(hold_done), .q(mcu_rst_n)
    );

    rsq_ctl_reg #(.AW(AW), .CTL_ADDR(0)) u_ctl (
        .clk(clk_mcu), .clr_n(pwrup_rst_n), .wr_allow(mcu_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ctl(ctl)
    );

    // software-driven domains, each released in its destination clock
    rsq_sync2 u_dsp_rst (
        .clk(clk_dsp), .clr_n(pwrup_rst_n), .d(ctl.dsp_run), .q(dsp_rst_n)
    );

    rsq_sync2 u_per_rst (
        .clk(clk_main), .clr_n(pwrup_rst_n), .d(ctl.dsp_run), .q(periph_rst_n)
    );

    rsq_sync2 u_slow_en (
        .clk(clk_slow), .clr_n(pwrup_rst_n), .d(ctl.slow_en), .q(slow_en_s)
    );

    // shared pins stay input on this side until the far processor is out of reset
    assign pad_oe_mcu = mcu_rst_n ? core_oe_mcu : '0;
    assign pad_oe_dsp = dsp_rst_n ? core_oe_dsp : '0;

endmodule

// File: rtl/rst_domain_seq_chk.sv
`timescale 1ns/1ps
module rst_domain_seq_chk #(
    parameter int unsigned MCU_IO_W = rsq_pkg::MCU_IO_W_DEF,
    parameter int unsigned DSP_IO_W = rsq_pkg::DSP_IO_W_DEF
) (
    input logic                clk_main,
    input logic                pwrup_rst_n,
    input logic                mcu_rst_n,
    input logic                dsp_rst_n,
    input logic                periph_rst_n,
    input logic                hold_done,
    input logic [MCU_IO_W-1:0] pad_oe_mcu,
    input logic [DSP_IO_W-1:0] pad_oe_dsp
);
    AST_MCU_PINS_INPUT: assert property (@(posedge clk_main) disable iff (!pwrup_rst_n)
        !mcu_rst_n |-> (pad_oe_mcu == '0)); // R9
    AST_DSP_PINS_INPUT: assert property (@(posedge clk_main) disable iff (!pwrup_rst_n)
        !dsp_rst_n |-> (pad_oe_dsp == '0)); // R9
    AST_DSP_AFTER_MCU: assert property (@(posedge clk_main) disable iff (!pwrup_rst_n)
        dsp_rst_n |-> mcu_rst_n); // R6
    AST_PERIPH_AFTER_MCU: assert property (@(posedge clk_main) disable iff (!pwrup_rst_n)
        periph_rst_n |-> mcu_rst_n); // R6
    AST_MCU_HOLD_DONE: assert property (@(posedge clk_main) disable iff (!pwrup_rst_n)
        mcu_rst_n |-> hold_done); // R4

    always @(negedge clk_main) begin
        if (!pwrup_rst_n) begin
            AST_ALL_HELD: assert (!mcu_rst_n && !dsp_rst_n && !periph_rst_n); // R1
        end
    end
endmodule

bind rst_domain_seq rst_domain_seq_chk #(.MCU_IO_W(MCU_IO_W), .DSP_IO_W(DSP_IO_W)) u_chk (
    .clk_main(clk_main), .pwrup_rst_n(pwrup_rst_n), .mcu_rst_n(mcu_rst_n),
    .dsp_rst_n(dsp_rst_n), .periph_rst_n(periph_rst_n), .hold_done(hold_done),
    .pad_oe_mcu(pad_oe_mcu), .pad_oe_dsp(pad_oe_dsp)
);

// File: tb/tb_rst_domain_seq.sv
`timescale 1ns/1ps
module tb_rst_domain_seq;
    localparam int HOLD = 128;
    localparam int MW   = 8;
    localparam int DW   = 16;
    localparam int AW   = 4;

    logic          clk_main    = 1'b0;
    logic          clk_slow    = 1'b0;
    logic          pwrup_rst_n = 1'b0;
    logic          wr_en       = 1'b0;
    logic [AW-1:0] wr_addr     = '0;
    logic [1:0]    wr_data     = '0;
    logic [MW-1:0] core_oe_mcu = 8'hA5;
    logic [DW-1:0] core_oe_dsp = 16'h3C5A;

    logic          clk_mcu, clk_dsp, clk_slow_out;
    logic          mcu_rst_n, dsp_rst_n, periph_rst_n;
    logic [MW-1:0] pad_oe_mcu;
    logic [DW-1:0] pad_oe_dsp;

    always #4  clk_main = ~clk_main;   // 125 MHz
    always #28 clk_slow = ~clk_slow;

    rst_domain_seq #(.MCU_HOLD_CYCLES(HOLD), .MCU_IO_W(MW), .DSP_IO_W(DW), .AW(AW)) dut (
        .clk_main(clk_main), .clk_slow(clk_slow), .pwrup_rst_n(pwrup_rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .core_oe_mcu(core_oe_mcu), .core_oe_dsp(core_oe_dsp),
        .clk_mcu(clk_mcu), .clk_dsp(clk_dsp), .clk_slow_out(clk_slow_out),
        .mcu_rst_n(mcu_rst_n), .dsp_rst_n(dsp_rst_n), .periph_rst_n(periph_rst_n),
        .pad_oe_mcu(pad_oe_mcu), .pad_oe_dsp(pad_oe_dsp)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int dsp_edges  = 0;
    int slow_edges = 0;
    always @(posedge clk_dsp)      dsp_edges++;
    always @(posedge clk_slow_out) slow_edges++;

    // reference model of the control-processor release, per power-up epoch
    int      epoch     = 0;
    int      mon_epoch = 0;
    int      mcu_edges = 0;
    bit      mcu_rel_model = 1'b0;
    realtime last_t = 0;

    always @(posedge clk_mcu) begin
        if (mon_epoch != epoch) begin
            mon_epoch = epoch;
            mcu_edges = 0;
        end
        mcu_edges++;
        if (mcu_edges >= 2) chk("R3 clk_mcu period ns", 32'(int'($realtime - last_t)), 32'd16);
        last_t = $realtime;
        mcu_rel_model = (mcu_edges >= HOLD + 2);
        #1;
        chk("R4 mcu_rst_n at counted edge", 32'(mcu_rst_n), 32'(mcu_rel_model));
    end

    // per-cycle comparison of the control-side pin direction
    always @(negedge clk_main) begin
        logic rel;
        rel = pwrup_rst_n && (mon_epoch == epoch) && mcu_rel_model;
        chk("R9 pad_oe_mcu", 32'(pad_oe_mcu), rel ? 32'(core_oe_mcu) : 32'd0);
    end

    task automatic do_write(input logic [AW-1:0] a, input logic [1:0] d);
        @(posedge clk_mcu); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk_mcu); #2;
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog R4 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int s0;
        repeat (5) @(posedge clk_main); #2;
        // R1 R3 R5 R2: everything held and quiet while power-up reset is low
        chk("R1 mcu_rst_n held", 32'(mcu_rst_n), 32'd0);
        chk("R1 dsp_rst_n held", 32'(dsp_rst_n), 32'd0);
        chk("R1 periph_rst_n held", 32'(periph_rst_n), 32'd0);
        chk("R1 pad_oe_dsp input", 32'(pad_oe_dsp), 32'd0);
        chk("R3 no clk_mcu edges in reset", 32'(mcu_edges), 32'd0);
        chk("R5 no clk_dsp edges in reset", 32'(dsp_edges), 32'd0);
        chk("R2 no slow edges in reset", 32'(slow_edges), 32'd0);

        pwrup_rst_n = 1'b1;

        // R8: writes while the control processor is in reset are ignored
        wait (mcu_edges >= 20);
        @(posedge clk_mcu); #2;
        wr_en = 1'b1; wr_addr = '0; wr_data = 2'b11;
        repeat (30) @(posedge clk_mcu);
        #2 wr_en = 1'b0;

        wait (mcu_edges >= HOLD + 6);
        @(posedge clk_main); #2;
        chk("R4 mcu_rst_n released", 32'(mcu_rst_n), 32'd1);
        chk("R6 dsp_rst_n held after mcu start", 32'(dsp_rst_n), 32'd0);
        chk("R6 periph_rst_n held after mcu start", 32'(periph_rst_n), 32'd0);
        chk("R8 write in reset ignored (slow clock)", 32'(slow_edges), 32'd0);
        chk("R5 clk_dsp ran during dsp reset", 32'(dsp_edges >= 2 * HOLD), 32'd1);
        chk("R9 pad_oe_dsp input while dsp reset", 32'(pad_oe_dsp), 32'd0);

        // R8: wrong address ignored
        do_write(4'd1, 2'b11);
        repeat (30) @(posedge clk_main); #1;
        chk("R8 wrong address dsp_rst_n", 32'(dsp_rst_n), 32'd0);
        chk("R8 wrong address slow clock", 32'(slow_edges), 32'd0);

        // R6: release
        do_write(4'd0, 2'b01);
        repeat (4) @(posedge clk_main); #1;
        chk("R6 dsp_rst_n released", 32'(dsp_rst_n), 32'd1);
        chk("R6 periph_rst_n released", 32'(periph_rst_n), 32'd1);
        chk("R9 pad_oe_dsp follows core", 32'(pad_oe_dsp), 32'(core_oe_dsp));
        s0 = slow_edges;
        repeat (20) @(posedge clk_main); #1;
        chk("R2 slow clock still gated", 32'(slow_edges - s0), 32'd0);

        // R2: enable slow clock
        do_write(4'd0, 2'b11);
        s0 = slow_edges;
        repeat (40) @(posedge clk_main); #1;
        chk("R2 slow clock running", 32'(slow_edges - s0 >= 3), 32'd1);

        // R7: reassert via write, slow clock stays on
        do_write(4'd0, 2'b10);
        repeat (4) @(posedge clk_main); #1;
        chk("R7 dsp_rst_n reasserted", 32'(dsp_rst_n), 32'd0);
        chk("R7 periph_rst_n reasserted", 32'(periph_rst_n), 32'd0);
        chk("R9 pad_oe_dsp back to input", 32'(pad_oe_dsp), 32'd0);

        // R2: disable slow clock again, release dsp
        do_write(4'd0, 2'b01);
        repeat (30) @(posedge clk_main);
        s0 = slow_edges;
        repeat (30) @(posedge clk_main); #1;
        chk("R2 slow clock stopped", 32'(slow_edges - s0), 32'd0);
        chk("R6 dsp_rst_n released again", 32'(dsp_rst_n), 32'd1);

        // R10: asynchronous assertion on power-up reset fall
        @(posedge clk_main); #2;
        pwrup_rst_n = 1'b0;
        epoch++;
        #1;
        chk("R10 periph_rst_n async", 32'(periph_rst_n), 32'd0);
        chk("R10 dsp_rst_n async", 32'(dsp_rst_n), 32'd0);
        chk("R10 mcu_rst_n async", 32'(mcu_rst_n), 32'd0);

        repeat (4) @(posedge clk_main); #2;
        pwrup_rst_n = 1'b1;
        wait ((mon_epoch == epoch) && (mcu_edges >= HOLD + 6));
        @(posedge clk_main); #2;
        chk("R4 mcu_rst_n released after power cycle", 32'(mcu_rst_n), 32'd1);
        chk("R1 control word cleared (dsp)", 32'(dsp_rst_n), 32'd0);
        chk("R1 control word cleared (periph)", 32'(periph_rst_n), 32'd0);

        finish_run();
    end
endmodule